// File: doc/BRIEF.md
# USB Host Frame Timer

This block paces start-of-frame events for a USB host controller. A 16-bit interval register, writable at any time and readable back, holds the frame length in PHY clocks. A down-counter shows how much of the current frame is left. Each time that counter expires, it reloads and emits a one-cycle start-of-frame strobe. A 14-bit frame number steps forward on every strobe and wraps back to zero after its maximum value.

The host-enable input gates the whole timer. While it is low, the remaining-time value and the frame number are frozen and no strobe appears. On the first enabled cycle, the remaining-time counter is loaded from the interval register and counting begins. A new interval value does not cut the running frame short. It is picked up at the next reload.

Top module: `host_frame_timer`

## Requirements
- R1: After reset, `ivl_o` reads 60000 (0xEA60), `frame_num_o` reads 0x3FFF, `remaining_o` reads 0 and `sof_o` is low.
- R2: A write (`ivl_we_i` high at a clock edge) makes `ivl_o` show `ivl_wdata_i` from the next cycle on.
- R3: While the timer is running and `remaining_o` is nonzero, `remaining_o` falls by exactly 1 per clock.
- R4: While running, a clock edge at which `remaining_o` is 0 reloads it with the interval minus one (0 when the interval is 0) and raises `sof_o` for that one following cycle. With an interval N ≥ 1, consecutive strobes are therefore N clocks apart.
- R5: `frame_num_o` advances by one at exactly the edge that raises `sof_o`, and is otherwise unchanged.
- R6: The frame number after 0x3FFF is 0. Because the reset value is 0x3FFF, the first strobe after reset shows frame number 0.
- R7: A write to the interval during a frame leaves `remaining_o` untouched. The next reload uses the new value. A write at the same edge as a reload is applied only to the reload after that.
- R8: While `host_en_i` is low, `remaining_o` and `frame_num_o` hold and `sof_o` stays low.
- R9: At the first edge with `host_en_i` high after reset or after a low period, `remaining_o` loads the interval minus one (0 for interval 0), `sof_o` stays low and the frame number is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PHY clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_en_i | input | 1 | Host enable; gates the timer |
| ivl_we_i | input | 1 | Interval write strobe |
| ivl_wdata_i | input | 16 | Interval write value in PHY clocks |
| ivl_o | output | 16 | Current interval register value |
| sof_o | output | 1 | Start-of-frame strobe, one cycle |
| frame_num_o | output | 14 | Frame number |
| remaining_o | output | 16 | Clocks left in the current frame |

## Verification
The hardest situation to reach is the frame number wrapping from 0x3FFF to 0 after the first one. At the default interval that takes almost a billion clocks. The bench first programs an interval of 1, so a strobe occurs on every clock, and then runs more than 16384 frames. Mid-frame writes, writes that land exactly on a reload edge, and enable drops in the middle of a frame come from random stimulus that uses short intervals. Directed sequences add the interval-0 case and the restart after re-enable.

// File: rtl/hft_pkg.sv
package hft_pkg;
  localparam int unsigned IVL_W      = 16;
  localparam int unsigned FNUM_W     = 14;
  localparam logic [IVL_W-1:0] IVL_RST = 16'hEA60;
endpackage

// File: rtl/hft_ivl_reg.sv
module hft_ivl_reg #(
  parameter int unsigned IVL_W = hft_pkg::IVL_W,
  parameter logic [IVL_W-1:0] IVL_RST = hft_pkg::IVL_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IVL_W-1:0] wdata_i,
  output logic [IVL_W-1:0] ivl_o,
  output logic [IVL_W-1:0] reload_o
);
  logic [IVL_W-1:0] ivl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ivl_q <= IVL_RST;
    else if (we_i) ivl_q <= wdata_i;
  end

  // counter runs reload..0, so the frame spans ivl_q clocks
  always_comb begin
    if (ivl_q == '0) reload_o = '0;
    else             reload_o = ivl_q - 1'b1;
  end

  assign ivl_o = ivl_q;

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ivl_q == $past(wdata_i)); // R2
endmodule

// File: rtl/hft_rem_cnt.sv
module hft_rem_cnt #(
  parameter int unsigned IVL_W = hft_pkg::IVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cnt_en_i,
  input  logic [IVL_W-1:0] reload_i,
  output logic             tick_o,
  output logic             sof_o,
  output logic [IVL_W-1:0] rem_o
);
  logic [IVL_W-1:0] cnt_q;
  logic             sof_q;

  assign tick_o = cnt_en_i && !start_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else begin
      sof_q <= tick_o;
      if (start_i || tick_o) cnt_q <= reload_i;
      else if (cnt_en_i)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rem_o = cnt_q;
  assign sof_o = sof_q;

  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_RELOAD_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !start_i && cnt_q == '0) |=> (sof_q && cnt_q == $past(reload_i))); // R4
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !start_i) |=> ($stable(cnt_q) && !sof_q)); // R8
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!sof_q && cnt_q == $past(reload_i))); // R9
endmodule

// File: rtl/hft_fnum_cnt.sv
module hft_fnum_cnt #(
  parameter int unsigned FNUM_W = hft_pkg::FNUM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [FNUM_W-1:0] fnum_o
);
  localparam logic [FNUM_W-1:0] FNUM_MAX = '1;

  logic [FNUM_W-1:0] fnum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fnum_q <= FNUM_MAX;
    else if (inc_i) fnum_q <= (fnum_q == FNUM_MAX) ? '0 : fnum_q + 1'b1;
  end

  assign fnum_o = fnum_q;

  AST_FNUM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && fnum_q == FNUM_MAX) |=> fnum_q == '0); // R6
  AST_FNUM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && fnum_q != FNUM_MAX) |=> fnum_q == $past(fnum_q) + 1'b1); // R5
  AST_FNUM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(fnum_q)); // R5
endmodule

// File: rtl/host_frame_timer.sv
module host_frame_timer #(
  parameter int unsigned IVL_W  = hft_pkg::IVL_W,
  parameter int unsigned FNUM_W = hft_pkg::FNUM_W,
  parameter logic [IVL_W-1:0] IVL_RST = hft_pkg::IVL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_en_i,
  input  logic              ivl_we_i,
  input  logic [IVL_W-1:0]  ivl_wdata_i,
  output logic [IVL_W-1:0]  ivl_o,
  output logic              sof_o,
  output logic [FNUM_W-1:0] frame_num_o,
  output logic [IVL_W-1:0]  remaining_o
);
  logic             run_q;
  logic             start;
  logic             cnt_en;
  logic             tick;
  logic [IVL_W-1:0] reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= host_en_i;
  end

  assign start  = host_en_i && !run_q;
  assign cnt_en = host_en_i && run_q;

  hft_ivl_reg #(.IVL_W(IVL_W), .IVL_RST(IVL_RST)) u_ivl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ivl_we_i),
    .wdata_i  (ivl_wdata_i),
    .ivl_o    (ivl_o),
    .reload_o (reload)
  );

  hft_rem_cnt #(.IVL_W(IVL_W)) u_rem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cnt_en_i (cnt_en),
    .reload_i (reload),
    .tick_o   (tick),
    .sof_o    (sof_o),
    .rem_o    (remaining_o)
  );

  hft_fnum_cnt #(.FNUM_W(FNUM_W)) u_fnum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .fnum_o (frame_num_o)
  );

  AST_SOF_FNUM_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> frame_num_o != $past(frame_num_o)); // R5
  AST_OFF_NO_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_en_i |=> (!sof_o && $stable(frame_num_o) && $stable(remaining_o))); // R8
endmodule

// File: tb/tb_host_frame_timer.sv
`timescale 1ns/1ps
module tb_host_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0;
  logic        ivl_we = 1'b0;
  logic [15:0] ivl_wdata = '0;
  logic [15:0] ivl_o;
  logic        sof_o;
  logic [13:0] fnum_o;
  logic [15:0] rem_o;

  always #2 clk = ~clk;

  host_frame_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .host_en_i(host_en), .ivl_we_i(ivl_we),
    .ivl_wdata_i(ivl_wdata), .ivl_o(ivl_o), .sof_o(sof_o),
    .frame_num_o(fnum_o), .remaining_o(rem_o)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  int unsigned wraps = 0;
  bit          done = 1'b0;

  // reference model built from the requirements
  logic [15:0] m_ivl, m_rem;
  logic [13:0] m_fn;
  logic        m_sof, m_run;

  function automatic logic [15:0] rl(input logic [15:0] v);
    return (v == 16'd0) ? 16'd0 : v - 16'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ivl <= 16'hEA60; m_rem <= '0; m_fn <= 14'h3FFF; m_sof <= 1'b0; m_run <= 1'b0;
    end else begin
      m_sof <= 1'b0;
      if (host_en && !m_run) m_rem <= rl(m_ivl);            // R9
      else if (host_en) begin
        if (m_rem == 16'd0) begin                           // R4
          m_rem <= rl(m_ivl);
          m_sof <= 1'b1;
          m_fn  <= (m_fn == 14'h3FFF) ? 14'd0 : m_fn + 14'd1; // R5 R6
        end else m_rem <= m_rem - 16'd1;                    // R3
      end
      m_run <= host_en;
      if (ivl_we) m_ivl <= ivl_wdata;                       // R2 R7
    end
  end

  task automatic cmp(input string tag, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s cyc=%0d actual=0x%0h expected=0x%0h", tag, req, cyc, act, exp);
    end
  endtask

  // called at the falling edge: compare, then drive next inputs
  task automatic step(input string tag, input bit en, input bit we, input logic [15:0] wd);
    @(negedge clk);
    cmp(tag, "R2 ivl", ivl_o, m_ivl);
    cmp(tag, "R3 remaining", rem_o, m_rem);
    cmp(tag, "R4 sof", {15'd0, sof_o}, {15'd0, m_sof});
    cmp(tag, "R5 frame", {2'd0, fnum_o}, {2'd0, m_fn});
    if (sof_o && fnum_o == 14'd0) wraps++;
    host_en = en; ivl_we = we; ivl_wdata = wd;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    int unsigned w0;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    @(negedge clk);
    cmp("R1", "R1 ivl", ivl_o, 16'hEA60);
    cmp("R1", "R1 frame", {2'd0, fnum_o}, 16'h3FFF);
    cmp("R1", "R1 remaining", rem_o, 16'd0);
    cmp("R1", "R1 sof", {15'd0, sof_o}, 16'd0);
    // R8 idle while disabled, R2 write while idle
    for (int i = 0; i < 8; i++) step("R8", 1'b0, 1'b0, 16'd0);
    step("R2", 1'b0, 1'b1, 16'd5);
    step("R2", 1'b0, 1'b0, 16'd0);
    // R9 start, then first SOF carries frame 0 (R6)
    step("R9", 1'b1, 1'b0, 16'd0);
    for (int i = 0; i < 12; i++) step("R6", 1'b1, 1'b0, 16'd0);
    // R7 mid-frame write of a longer then shorter interval
    step("R7", 1'b1, 1'b1, 16'd9);
    for (int i = 0; i < 14; i++) step("R7", 1'b1, 1'b0, 16'd0);
    step("R7", 1'b1, 1'b1, 16'd3);
    for (int i = 0; i < 20; i++) step("R7", 1'b1, 1'b0, 16'd0);
    // interval 0 behaves as reload 0 (R4)
    step("R4", 1'b1, 1'b1, 16'd0);
    for (int i = 0; i < 8; i++) step("R4", 1'b1, 1'b0, 16'd0);
    // R8 drop mid-frame, R9 restart
    step("R8", 1'b1, 1'b1, 16'd7);
    for (int i = 0; i < 4; i++) step("R8", 1'b1, 1'b0, 16'd0);
    for (int i = 0; i < 10; i++) step("R8", 1'b0, 1'b0, 16'd0);
    for (int i = 0; i < 12; i++) step("R9", 1'b1, 1'b0, 16'd0);
    // random mix of enables and short interval writes
    for (int i = 0; i < 4000; i++) begin
      bit en, we;
      en = ($urandom_range(0, 99) < 94);
      we = ($urandom_range(0, 99) < 4);
      w0 = $urandom_range(0, 12);
      step("RND", en, we, w0[15:0]);
    end
    // R6 wrap: strobe every clock, run past a full frame-number cycle
    step("R6", 1'b1, 1'b1, 16'd1);
    wraps = 0;
    for (int i = 0; i < 16500; i++) step("R6", 1'b1, 1'b0, 16'd0);
    n_chk++;
    if (wraps == 0) begin
      n_bad++;
      $display("FAIL R6 wrap actual=%0d expected>=1", wraps);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule